// File: doc/BRIEF.md
# Temperature Sensor Controller

This block is an APB slave that sits between software and an on-die temperature sensor. It divides the system clock down to a sensor clock whose rate software sets. It drives the sensor's active-low reset and power-down pins and a 5-bit offset-trim bus, all straight from fields of a control register. The analog sensor is represented by a data/valid input pair. Every valid reading is captured and can be read back.

A threshold register holds a limit. When alarm checking is enabled, any reading at or above the limit sets a sticky alarm flag in the status register. The flag stays set until software writes a 1 to its bit. All accesses complete in a single access phase with no wait states.

Register layout, byte offsets on `paddr`:
- 0x00 control: `[25:16]` clock divisor, `[8]` alarm enable, `[7]` power-down (active low), `[6:2]` trim, `[1]` sensor reset (active low), `[0]` clock enable.
- 0x04 status: `[DATA_W-1:0]` last valid reading, `[16]` alarm flag.
- 0x08 threshold: `[DATA_W-1:0]` limit.

With the default `DATA_W` of 10, the status register's reading occupies bits `[9:0]` and the threshold occupies bits `[9:0]`.

Top module: `tsens_ctrl`

## Requirements
- R1: After reset, every register reads 0, `sns_clk` is 0, and `sns_rst_n`, `sns_pd_n` and `sns_trim` are all 0.
- R2: `sns_rst_n` equals control bit 1, `sns_pd_n` equals control bit 7, and `sns_trim` equals control bits 6:2. Each output follows one cycle after the register is written.
- R3: With control bit 0 set and a nonzero divisor D in control bits 25:16, `sns_clk` is periodic with a period of 2*D system clock cycles.
- R4: With control bit 0 cleared and a nonzero divisor, `sns_clk` holds its value.
- R5: With a divisor of 0, `sns_clk` is driven low from the next cycle onward, whatever the state of the enable bit.
- R6: Status bits `[DATA_W-1:0]` return the reading captured on the most recent cycle in which `sns_valid` was high. Cycles without `sns_valid` leave that field unchanged, and so do writes to the status register.
- R7: When control bit 8 is set and a valid reading is greater than or equal to the threshold, status bit 16 becomes 1. A reading below the threshold does not set it, and neither does any reading while bit 8 is 0.
- R8: Status bit 16 stays set until a write to offset 0x04 with data bit 16 set clears it. A write with data bit 16 at 0 leaves the flag unchanged.
- R9: If a clearing write and an alarm-setting reading fall in the same cycle, status bit 16 ends up set.
- R10: Reserved control bits and threshold bits above `DATA_W` read 0 regardless of what was written. Offsets 0x0C and above read 0 and ignore writes.
- R11: `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | System clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always 0 |
| sns_data | input | DATA_W | Sensor reading |
| sns_valid | input | 1 | Reading valid strobe |
| sns_clk | output | 1 | Divided sensor clock |
| sns_rst_n | output | 1 | Sensor reset, active low |
| sns_pd_n | output | 1 | Sensor power-down, active low |
| sns_trim | output | 5 | Offset-correction value |

## Verification
The threshold compare is driven by a table of reading/limit pairs. The table includes readings exactly on the limit, one below it and one above it, at both the low and the full-scale ends of the range, plus one case with alarm enable off. Together these separate a greater-or-equal compare from a strict compare, from an off-by-one, and from an ungated compare. The divider is measured at two divisors, which tells a 2*D period apart from a period of D or D+1. It is also held with enable off and with a divisor of zero. The sticky flag is probed with a write of 0, a write of 1, and a clear that lands in the same cycle as a new alarm.

// File: rtl/tsens_ctrl.sv
module tsens_ctrl #(
  parameter int DATA_W    = 10,
  parameter int DIV_W     = 10,
  parameter int ALARM_BIT = 16
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [7:0]        paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [DATA_W-1:0] sns_data,
  input  logic              sns_valid,
  output logic              sns_clk,
  output logic              sns_rst_n,
  output logic              sns_pd_n,
  output logic [4:0]        sns_trim
);
  localparam int DIV_LSB = 16;

  logic [DIV_W-1:0]  div_q, cnt_q;
  logic [DATA_W-1:0] thres_q, last_q;
  logic [4:0]        trim_q;
  logic              alarm_en_q, pd_n_q, rst_n_q, clk_en_q, alarm_q, sclk_q;
  logic              wr, wr_ctrl, wr_stat, wr_thr, hit, clr;
  logic              unused_wdata;

  assign unused_wdata = ^pwdata;
  assign wr      = psel & penable & pwrite;
  assign wr_ctrl = wr && (paddr == 8'h00);
  assign wr_stat = wr && (paddr == 8'h04);
  assign wr_thr  = wr && (paddr == 8'h08);
  assign hit     = sns_valid && alarm_en_q && (sns_data >= thres_q);
  assign clr     = wr_stat && pwdata[ALARM_BIT];

  assign pready    = 1'b1;
  assign pslverr   = 1'b0;
  assign sns_clk   = sclk_q;
  assign sns_rst_n = rst_n_q;
  assign sns_pd_n  = pd_n_q;
  assign sns_trim  = trim_q;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      div_q      <= '0;
      alarm_en_q <= 1'b0;
      pd_n_q     <= 1'b0;
      trim_q     <= '0;
      rst_n_q    <= 1'b0;
      clk_en_q   <= 1'b0;
      thres_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        div_q      <= pwdata[DIV_LSB +: DIV_W];
        alarm_en_q <= pwdata[8];
        pd_n_q     <= pwdata[7];
        trim_q     <= pwdata[6:2];
        rst_n_q    <= pwdata[1];
        clk_en_q   <= pwdata[0];
      end
      if (wr_thr) thres_q <= pwdata[DATA_W-1:0];
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      last_q  <= '0;
      alarm_q <= 1'b0;
    end else begin
      if (sns_valid) last_q <= sns_data;
      alarm_q <= hit | (alarm_q & ~clr);
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (div_q == '0) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!clk_en_q) begin
      cnt_q  <= '0;
    end else if (cnt_q >= div_q - 1'b1) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    prdata = '0;
    unique case (paddr)
      8'h00: begin
        prdata[DIV_LSB +: DIV_W] = div_q;
        prdata[8:0] = {alarm_en_q, pd_n_q, trim_q, rst_n_q, clk_en_q};
      end
      8'h04: begin
        prdata[DATA_W-1:0] = last_q;
        prdata[ALARM_BIT]  = alarm_q;
      end
      8'h08: prdata[DATA_W-1:0] = thres_q;
      default: prdata = '0;
    endcase
  end
endmodule

// File: rtl/tsens_ctrl_chk.sv
module tsens_ctrl_chk #(
  parameter int DATA_W    = 10,
  parameter int DIV_W     = 10,
  parameter int ALARM_BIT = 16
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [7:0]        paddr,
  input logic [31:0]       pwdata,
  input logic              pready,
  input logic              pslverr,
  input logic [DATA_W-1:0] sns_data,
  input logic              sns_valid,
  input logic              sns_clk,
  input logic              clk_en,
  input logic              alarm_en,
  input logic [DIV_W-1:0]  div,
  input logic [DATA_W-1:0] thres,
  input logic [DATA_W-1:0] last,
  input logic              alarm
);
  logic hit_c, clr_c;
  assign hit_c = sns_valid && alarm_en && (sns_data >= thres);
  assign clr_c = psel && penable && pwrite && (paddr == 8'h04) && pwdata[ALARM_BIT];

  AST_PREADY_HI: assert property (@(posedge pclk) disable iff (!presetn)
    pready && !pslverr); // R11
  AST_ALARM_SET: assert property (@(posedge pclk) disable iff (!presetn)
    hit_c |=> alarm); // R7
  AST_ALARM_CLR: assert property (@(posedge pclk) disable iff (!presetn)
    (clr_c && !hit_c) |=> !alarm); // R8
  AST_ALARM_STICKY: assert property (@(posedge pclk) disable iff (!presetn)
    (alarm && !clr_c) |=> alarm); // R8
  AST_SET_WINS: assert property (@(posedge pclk) disable iff (!presetn)
    (hit_c && clr_c) |=> alarm); // R9
  AST_DIV0_LOW: assert property (@(posedge pclk) disable iff (!presetn)
    (div == '0) |=> !sns_clk); // R5
  AST_CLK_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
    (!clk_en && div != '0) |=> $stable(sns_clk)); // R4
  AST_LAST_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
    !sns_valid |=> $stable(last)); // R6
endmodule

bind tsens_ctrl tsens_ctrl_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W), .ALARM_BIT(ALARM_BIT)) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .pready(pready), .pslverr(pslverr),
  .sns_data(sns_data), .sns_valid(sns_valid), .sns_clk(sns_clk),
  .clk_en(clk_en_q), .alarm_en(alarm_en_q), .div(div_q), .thres(thres_q),
  .last(last_q), .alarm(alarm_q)
);

// File: tb/tsens_ctrl_tb.sv
`timescale 1ns/1ps
module tsens_ctrl_tb;
  logic        pclk = 0, presetn = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic        pready, pslverr;
  logic [9:0]  sns_data = 0;
  logic        sns_valid = 0;
  logic        sns_clk, sns_rst_n, sns_pd_n;
  logic [4:0]  sns_trim;
  int errors = 0, checks = 0;
  logic [31:0] rd;

  always #2 pclk = ~pclk;

  tsens_ctrl u_dut (.*);

  // {en, exp_alarm, thres[9:0], data[9:0]}
  localparam logic [21:0] VEC [7] = '{
    {1'b1, 1'b1, 10'd100,  10'd100},
    {1'b1, 1'b0, 10'd100,  10'd99},
    {1'b1, 1'b1, 10'd100,  10'd101},
    {1'b0, 1'b0, 10'd0,    10'd500},
    {1'b1, 1'b1, 10'd0,    10'd0},
    {1'b1, 1'b0, 10'd1023, 10'd1022},
    {1'b1, 1'b1, 10'd1023, 10'd1023}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 0; paddr = a;
    @(negedge pclk); penable = 1; #0.5 d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic pulse(input logic [9:0] v);
    @(negedge pclk); sns_valid = 1; sns_data = v;
    @(negedge pclk); sns_valid = 0; sns_data = 10'h155;
  endtask

  task automatic measure(output int per);
    int n = 0;
    per = 0;
    while (!(sns_clk === 1'b0) && n < 200) begin @(negedge pclk); n++; end
    while (!(sns_clk === 1'b1) && n < 200) begin @(negedge pclk); n++; end
    while (!(sns_clk === 1'b0) && n < 200) begin @(negedge pclk); n++; per++; end
    while (!(sns_clk === 1'b1) && n < 200) begin @(negedge pclk); n++; per++; end
  endtask

  initial begin
    repeat (100000) @(posedge pclk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int per;
    logic held;
    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);
    // R1 reset state
    chk("R1 pins", {29'b0, sns_clk, sns_rst_n, sns_pd_n}, 32'd0);
    chk("R1 trim", {27'b0, sns_trim}, 32'd0);
    apb_rd(8'h00, rd); chk("R1 ctrl", rd, 32'd0);
    apb_rd(8'h04, rd); chk("R1 status", rd, 32'd0);
    apb_rd(8'h08, rd); chk("R1 thres", rd, 32'd0);
    chk("R11 ready/err", {30'b0, pready, pslverr}, 32'd2);

    // R7 R6 table of compare cases
    foreach (VEC[i]) begin
      apb_wr(8'h08, {22'b0, VEC[i][19:10]});
      apb_wr(8'h00, {23'b0, VEC[i][21], 8'h00});
      apb_wr(8'h04, 32'h0001_0000);
      pulse(VEC[i][9:0]);
      apb_rd(8'h04, rd);
      chk("R7 alarm", {31'b0, rd[16]}, {31'b0, VEC[i][20]});
      chk("R6 reading", {22'b0, rd[9:0]}, {22'b0, VEC[i][9:0]});
    end

    // R6 no valid / status write leaves reading
    pulse(10'd321);
    repeat (5) @(negedge pclk);
    apb_wr(8'h04, 32'h0000_03FF);
    apb_rd(8'h04, rd); chk("R6 hold", {22'b0, rd[9:0]}, 32'd321);

    // R8 sticky
    apb_wr(8'h08, 32'd50);
    apb_wr(8'h00, 32'h0000_0100);
    apb_wr(8'h04, 32'h0001_0000);
    pulse(10'd60);
    pulse(10'd10);
    apb_rd(8'h04, rd); chk("R8 sticky after low reading", {31'b0, rd[16]}, 32'd1);
    apb_wr(8'h04, 32'h0000_0000);
    apb_rd(8'h04, rd); chk("R8 write0 keeps", {31'b0, rd[16]}, 32'd1);
    // R9 clear and set together
    @(negedge pclk); psel = 1; pwrite = 1; paddr = 8'h04; pwdata = 32'h0001_0000;
    @(negedge pclk); penable = 1; sns_valid = 1; sns_data = 10'd70;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0; sns_valid = 0;
    apb_rd(8'h04, rd); chk("R9 set wins", {31'b0, rd[16]}, 32'd1);
    apb_wr(8'h04, 32'h0001_0000);
    apb_rd(8'h04, rd); chk("R8 write1 clears", {31'b0, rd[16]}, 32'd0);

    // R2 pins
    apb_wr(8'h00, 32'h0000_008E);
    chk("R2 rst/pd", {30'b0, sns_rst_n, sns_pd_n}, 32'd3);
    chk("R2 trim3", {27'b0, sns_trim}, 32'd3);
    apb_wr(8'h00, 32'h0000_007C);
    chk("R2 rst/pd off", {30'b0, sns_rst_n, sns_pd_n}, 32'd0);
    chk("R2 trim31", {27'b0, sns_trim}, 32'd31);

    // R10 reserved
    apb_wr(8'h00, 32'hFFFF_FFFF);
    apb_rd(8'h00, rd); chk("R10 ctrl mask", rd, 32'h03FF_01FF);
    apb_wr(8'h08, 32'hFFFF_FFFF);
    apb_rd(8'h08, rd); chk("R10 thres mask", rd, 32'h0000_03FF);
    apb_wr(8'h0C, 32'hFFFF_FFFF);
    apb_rd(8'h0C, rd); chk("R10 reserved 0C", rd, 32'd0);
    apb_wr(8'h40, 32'hFFFF_FFFF);
    apb_rd(8'h40, rd); chk("R10 reserved 40", rd, 32'd0);

    // R3 period
    apb_wr(8'h00, 32'h0003_0001);
    measure(per); chk("R3 period D=3", per, 32'd6);
    apb_wr(8'h00, 32'h0005_0001);
    measure(per); chk("R3 period D=5", per, 32'd10);

    // R4 hold with enable low
    apb_wr(8'h00, 32'h0004_0000);
    @(negedge pclk); held = sns_clk;
    per = 0;
    repeat (20) begin @(negedge pclk); if (sns_clk !== held) per++; end
    chk("R4 hold changes", per, 32'd0);

    // R5 divisor zero
    apb_wr(8'h00, 32'h0000_0001);
    per = 0;
    repeat (20) begin @(negedge pclk); if (sns_clk !== 1'b0) per++; end
    chk("R5 div0 low", per, 32'd0);
    chk("R11 ready/err end", {30'b0, pready, pslverr}, 32'd2);

    finish_run();
  end
endmodule